// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block is the 8-bit processor-facing register port placed in front of several independent framer register banks. It accepts either of two strobe conventions: separate active-low read and write strobes, or a single data strobe paired with a read/not-write line. It also accepts either of two addressing schemes: dedicated address pins, or an address carried on the data pins and captured by an address latch strobe. A chip select and a bank select route each access to exactly one bank.

The bus pins are treated as inputs that are already synchronous to `clk`. Strobe edges are found by comparing each cycle with the one before it. A write is captured while its strobe is active and is committed to the bank when the strobe ends. A read drives the register contents onto the data outputs for as long as the read strobe and chip select are both active.

The banks' status lines are combined into one interrupt request. The request is driven as an open-drain pull-down enable.

Top module: `hp_host_port`

## Requirements
- R1: After reset, `ad_oe` and `irq_pull` are 0 and every register of every bank reads 0.
- R2: When `bus_moto`=0, a read is `rd_ds`=0 with `wr_rw`=1, and a write is `wr_rw`=0 with `rd_ds`=1. Both strobes are active low.
- R3: When `bus_moto`=1, the data strobe is `rd_ds` and `wr_rw`=1 selects a read while `wr_rw`=0 selects a write. The data strobe is active low when `bus_mux`=0 and active high when `bus_mux`=1.
- R4: When `bus_mux`=0, the register address is `ale_a6` as bit 6 with `addr_lo[5:0]` as bits 5..0.
- R5: When `bus_mux`=1, the address is `ad_in[6:0]`, captured at the first clock on which `ale_a6` is seen high after being low. In this mode `addr_lo` and `ad_in[7]` have no effect on the address.
- R6: While `cs_n`=1, `ad_oe` stays 0 and write strobes change no register.
- R7: A write commits on the clock after its strobe (or chip select) goes inactive. It uses the bank, address and data present on the last cycle the strobe was active, and the new value is readable from that edge onward.
- R8: `fsel` selects the bank. A write changes only the addressed register of that one bank.
- R9: When `bus_moto`=0 and both strobes are low together, the port performs no access: `ad_oe` stays 0 and no register changes.
- R10: `irq_pull` is 1 on the clock after any bit of `bank_stat` is high, and 0 on the clock after all bits are low.
- R11: During a read, `ad_oe`=1 and `ad_out` is the addressed register of the selected bank. Otherwise `ad_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_moto | input | 1 | 1: data strobe plus read/not-write; 0: separate read and write strobes |
| bus_mux | input | 1 | 1: address carried on data pins; 0: dedicated address pins |
| cs_n | input | 1 | Active-low chip select |
| fsel | input | 2 | Bank select |
| addr_lo | input | 6 | Address bits 5..0 when not multiplexed |
| ale_a6 | input | 1 | Address bit 6, or address latch strobe when multiplexed |
| rd_ds | input | 1 | Read strobe or data strobe |
| wr_rw | input | 1 | Write strobe or read/not-write |
| ad_in | input | 8 | Data (and address, when multiplexed) from the bus |
| bank_stat | input | 4 | Per-bank status request lines |
| ad_out | output | 8 | Read data toward the bus |
| ad_oe | output | 1 | Drive enable for ad_out; 0 means bus released |
| irq_pull | output | 1 | 1 pulls the open-drain interrupt line low |

## Verification
Two events can land on the same clock edge in multiplexed mode: the commit of a finished write, and the capture of a new address on a rising latch strobe. The bench provokes this by releasing the write strobe and raising the latch strobe, with a different address, on the same falling edge. It then reads both addresses back. The written byte must appear only at the earlier address, and the register at the new address must be unchanged. A read that begins on the cycle of a commit to the same register is also sampled after the edge and must return the new byte.

// File: rtl/hp_pkg.sv
package hp_pkg;
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } hp_acc_e;

   function automatic logic lvl_active(input logic lvl, input logic act_high);
      return act_high ? lvl : ~lvl;
   endfunction
endpackage

// File: rtl/hp_strobe_decode.sv
module hp_strobe_decode
   import hp_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    bus_moto,
   input  logic    bus_mux,
   input  logic    cs_n,
   input  logic    rd_ds,
   input  logic    wr_rw,
   output hp_acc_e acc,
   output logic    wr_commit
);
   logic rd_on, wr_on, ds_on, wr_q;

   always_comb begin
      ds_on = lvl_active(rd_ds, bus_mux);
      if (bus_moto) begin
         rd_on = ds_on & wr_rw;
         wr_on = ds_on & ~wr_rw;
      end else begin
         rd_on = ~rd_ds;
         wr_on = ~wr_rw;
      end
      acc = ACC_IDLE;
      if (!cs_n) begin
         if (rd_on && !wr_on)      acc = ACC_READ;
         else if (wr_on && !rd_on) acc = ACC_WRITE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_q <= 1'b0;
      else        wr_q <= (acc == ACC_WRITE);
   end

   assign wr_commit = wr_q && (acc != ACC_WRITE);

   a_r6_no_access_without_cs: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (acc == ACC_IDLE));
endmodule

// File: rtl/hp_addr_path.sv
module hp_addr_path
   import hp_pkg::*;
#(
   parameter  int DATA_W = 8,
   parameter  int ADDR_W = 7,
   parameter  int BANK_W = 2,
   localparam int LO_W   = ADDR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_mux,
   input  logic              ale_a6,
   input  logic [LO_W-1:0]   addr_lo,
   input  logic [DATA_W-1:0] ad_in,
   input  logic [BANK_W-1:0] fsel,
   input  hp_acc_e           acc,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BANK_W-1:0] wr_bank,
   output logic [DATA_W-1:0] wr_data
);
   logic              ale_q;
   logic [ADDR_W-1:0] mux_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ale_q    <= 1'b0;
         mux_addr <= '0;
      end else begin
         ale_q <= ale_a6;
         if (bus_mux && ale_a6 && !ale_q) mux_addr <= ad_in[ADDR_W-1:0];
      end
   end

   assign cur_addr = bus_mux ? mux_addr : {ale_a6, addr_lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_addr <= '0;
         wr_bank <= '0;
         wr_data <= '0;
      end else if (acc == ACC_WRITE) begin
         wr_addr <= cur_addr;
         wr_bank <= fsel;
         wr_data <= ad_in;
      end
   end

   a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !ale_a6 |=> $stable(mux_addr));
endmodule

// File: rtl/hp_bank_file.sv
module hp_bank_file #(
   parameter  int NUM_BANKS = 4,
   parameter  int BANK_W    = 2,
   parameter  int ADDR_W    = 7,
   parameter  int DATA_W    = 8,
   localparam int DEPTH     = 2 ** ADDR_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_commit,
   input  logic [BANK_W-1:0]    wr_bank,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [BANK_W-1:0]    rd_bank,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_data,
   output logic [NUM_BANKS-1:0] bank_we
);
   logic [DATA_W-1:0] rd_vec [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [DATA_W-1:0] regs [DEPTH];

      assign bank_we[b] = wr_commit && (wr_bank == BANK_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
         end else if (bank_we[b]) begin
            regs[wr_addr] <= wr_data;
         end
      end

      assign rd_vec[b] = regs[rd_addr];
   end

   assign rd_data = rd_vec[rd_bank];

   a_r8_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_we));
endmodule

// File: rtl/hp_irq_combine.sv
module hp_irq_combine #(
   parameter int NUM_BANKS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] bank_stat,
   output logic                 irq_pull
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_pull <= 1'b0;
      else        irq_pull <= |bank_stat;
   end

   a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (|bank_stat) |=> irq_pull);
   a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !(|bank_stat) |=> !irq_pull);
endmodule

// File: rtl/hp_host_port.sv
module hp_host_port
   import hp_pkg::*;
#(
   parameter  int DATA_W    = 8,
   parameter  int ADDR_W    = 7,
   parameter  int NUM_BANKS = 4,
   localparam int BANK_W    = $clog2(NUM_BANKS),
   localparam int LO_W      = ADDR_W - 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_moto,
   input  logic                 bus_mux,
   input  logic                 cs_n,
   input  logic [BANK_W-1:0]    fsel,
   input  logic [LO_W-1:0]      addr_lo,
   input  logic                 ale_a6,
   input  logic                 rd_ds,
   input  logic                 wr_rw,
   input  logic [DATA_W-1:0]    ad_in,
   input  logic [NUM_BANKS-1:0] bank_stat,
   output logic [DATA_W-1:0]    ad_out,
   output logic                 ad_oe,
   output logic                 irq_pull
);
   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("hp_host_port: NUM_BANKS must be a power of two, at least 2");
   end
   if (ADDR_W > DATA_W || ADDR_W < 2) begin : g_bad_addr
      $error("hp_host_port: ADDR_W must fit on the data pins and be at least 2");
   end

   hp_acc_e               acc;
   logic                  wr_commit;
   logic [ADDR_W-1:0]     cur_addr, wr_addr;
   logic [BANK_W-1:0]     wr_bank;
   logic [DATA_W-1:0]     wr_data, rd_data;
   logic [NUM_BANKS-1:0]  bank_we;

   hp_strobe_decode u_dec (
      .clk(clk), .rst_n(rst_n), .bus_moto(bus_moto), .bus_mux(bus_mux),
      .cs_n(cs_n), .rd_ds(rd_ds), .wr_rw(wr_rw),
      .acc(acc), .wr_commit(wr_commit)
   );

   hp_addr_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .bus_mux(bus_mux), .ale_a6(ale_a6),
      .addr_lo(addr_lo), .ad_in(ad_in), .fsel(fsel), .acc(acc),
      .cur_addr(cur_addr), .wr_addr(wr_addr), .wr_bank(wr_bank), .wr_data(wr_data)
   );

   hp_bank_file #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
                  .DATA_W(DATA_W)) u_banks (
      .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .wr_bank(wr_bank),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_bank(fsel), .rd_addr(cur_addr),
      .rd_data(rd_data), .bank_we(bank_we)
   );

   hp_irq_combine #(.NUM_BANKS(NUM_BANKS)) u_irq (
      .clk(clk), .rst_n(rst_n), .bank_stat(bank_stat), .irq_pull(irq_pull)
   );

   assign ad_oe  = (acc == ACC_READ);
   assign ad_out = rd_data;

   a_r6_drive_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> !cs_n);
   a_r7_commit_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (|bank_we) |-> $past(acc == ACC_WRITE));
endmodule

// File: tb/hp_host_port_tb.sv
`timescale 1ns/1ps
module hp_host_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_moto = 1'b0, bus_mux = 1'b0, cs_n = 1'b1;
   logic [1:0] fsel = '0;
   logic [5:0] addr_lo = '0;
   logic       ale_a6 = 1'b0, rd_ds = 1'b1, wr_rw = 1'b1;
   logic [7:0] ad_in = '0;
   logic [3:0] bank_stat = '0;
   logic [7:0] ad_out;
   logic       ad_oe, irq_pull;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [7:0] exp_mem [4][128];

   always #2.5 clk = ~clk;

   hp_host_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_moto(bus_moto), .bus_mux(bus_mux),
      .cs_n(cs_n), .fsel(fsel), .addr_lo(addr_lo), .ale_a6(ale_a6),
      .rd_ds(rd_ds), .wr_rw(wr_rw), .ad_in(ad_in), .bank_stat(bank_stat),
      .ad_out(ad_out), .ad_oe(ad_oe), .irq_pull(irq_pull)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // returns {rd_ds, wr_rw} levels for the chosen convention
   function automatic logic [1:0] strobe_lvls(input bit moto, input bit mux,
                                               input bit active, input bit is_wr);
      logic ds_on;
      if (!moto) begin
         if (!active) return 2'b11;
         return is_wr ? 2'b10 : 2'b01;
      end
      ds_on = mux;
      if (!active) return {~ds_on, 1'b1};
      return {ds_on, ~is_wr};
   endfunction

   function automatic string req_tag(input bit moto, input bit mux);
      if (mux) return moto ? "R3/R5" : "R2/R5";
      return moto ? "R3/R4" : "R2/R4";
   endfunction

   task automatic set_addr_pins(input bit mux, input logic [6:0] addr);
      if (mux) begin
         @(negedge clk);
         ad_in   = {1'($urandom), addr};
         addr_lo = 6'($urandom);
         ale_a6  = 1'b1;
         @(negedge clk);
         ale_a6  = 1'b0;
      end else begin
         ale_a6  = addr[6];
         addr_lo = addr[5:0];
      end
   endtask

   task automatic access(input bit moto, input bit mux, input bit cs_on, input bit is_wr,
                         input logic [1:0] bank, input logic [6:0] addr, input logic [7:0] data);
      string tag;
      tag = req_tag(moto, mux);
      @(negedge clk);
      bus_moto = moto; bus_mux = mux; cs_n = 1'b1; ale_a6 = 1'b0;
      {rd_ds, wr_rw} = strobe_lvls(moto, mux, 1'b0, 1'b0);
      set_addr_pins(mux, addr);
      @(negedge clk);
      cs_n = ~cs_on; fsel = bank;
      ad_in = is_wr ? data : 8'($urandom);
      {rd_ds, wr_rw} = strobe_lvls(moto, mux, 1'b1, is_wr);
      @(posedge clk); #1;
      if (!is_wr) begin
         if (cs_on) begin
            check({tag, " R11 oe"}, 32'(ad_oe), 32'd1);
            check({tag, " R8 R11 data"}, 32'(ad_out), 32'(exp_mem[bank][addr]));
         end else begin
            check("R6 oe with cs high", 32'(ad_oe), 32'd0);
         end
      end else begin
         check("R11 no drive on write", 32'(ad_oe), 32'd0);
      end
      @(negedge clk);
      {rd_ds, wr_rw} = strobe_lvls(moto, mux, 1'b0, 1'b0);
      cs_n = 1'b1;
      if (is_wr && cs_on) exp_mem[bank][addr] = data;
      @(negedge clk);
   endtask

   initial begin
      for (int b = 0; b < 4; b++)
         for (int a = 0; a < 128; a++) exp_mem[b][a] = 8'h00;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      #1;
      check("R1 oe reset", 32'(ad_oe), 32'd0);
      check("R1 irq reset", 32'(irq_pull), 32'd0);
      rst_n = 1'b1;
      // R1: registers read as zero after reset
      access(0, 0, 1, 0, 2'd3, 7'h7F, 8'h00);
      access(1, 1, 1, 0, 2'd0, 7'h00, 8'h00);

      // R2 / R4 directed write and readback, other banks untouched (R8)
      access(0, 0, 1, 1, 2'd1, 7'h55, 8'hC3);
      access(0, 0, 1, 0, 2'd1, 7'h55, 8'h00);
      access(0, 0, 1, 0, 2'd2, 7'h55, 8'h00);

      // R6: write with chip select high changes nothing
      access(1, 0, 0, 1, 2'd1, 7'h55, 8'h11);
      access(1, 0, 0, 0, 2'd1, 7'h55, 8'h00);
      access(1, 0, 1, 0, 2'd1, 7'h55, 8'h00);

      // R9: both separate strobes low together
      @(negedge clk);
      bus_moto = 0; bus_mux = 0; ale_a6 = 1'b1; addr_lo = 6'h15; fsel = 2'd1;
      ad_in = 8'hA5; cs_n = 1'b0; rd_ds = 1'b0; wr_rw = 1'b0;
      @(posedge clk); #1;
      check("R9 no drive on dual strobe", 32'(ad_oe), 32'd0);
      @(negedge clk); rd_ds = 1'b1; wr_rw = 1'b1; cs_n = 1'b1;
      @(negedge clk);
      access(0, 0, 1, 0, 2'd1, 7'h55, 8'h00);

      // R3: data strobe at the wrong polarity for non-multiplexed mode is no access
      @(negedge clk);
      bus_moto = 1; bus_mux = 0; ale_a6 = 1'b0; addr_lo = 6'h01; fsel = 2'd0;
      rd_ds = 1'b1; wr_rw = 1'b0; ad_in = 8'h77; cs_n = 1'b0;
      @(posedge clk); #1;
      check("R3 idle strobe no drive", 32'(ad_oe), 32'd0);
      @(negedge clk); wr_rw = 1'b1; cs_n = 1'b1;
      @(negedge clk);
      access(1, 0, 1, 0, 2'd0, 7'h01, 8'h00);

      // R5 and R7: commit and new address latch on the same edge
      access(0, 1, 1, 0, 2'd2, 7'h33, 8'h00);
      @(negedge clk);
      bus_moto = 0; bus_mux = 1;
      ad_in = 8'h90; ale_a6 = 1'b1;           // address 0x10
      @(negedge clk); ale_a6 = 1'b0;
      cs_n = 1'b0; fsel = 2'd2; ad_in = 8'h5E; wr_rw = 1'b0;
      @(negedge clk);
      wr_rw = 1'b1; cs_n = 1'b1; ad_in = 8'h33; ale_a6 = 1'b1;   // new address 0x33
      @(negedge clk); ale_a6 = 1'b0;
      exp_mem[2][7'h10] = 8'h5E;
      @(negedge clk);
      cs_n = 1'b0; rd_ds = 1'b0;
      @(posedge clk); #1;
      check("R5 R7 concurrent latch keeps other register", 32'(ad_out), 32'(exp_mem[2][7'h33]));
      @(negedge clk); rd_ds = 1'b1; cs_n = 1'b1;
      access(0, 0, 1, 0, 2'd2, 7'h10, 8'h00);
      check("R7 committed at captured address", 32'(exp_mem[2][7'h10]), 32'h5E);

      // R7: read starting on the commit cycle sees new data
      @(negedge clk);
      bus_moto = 0; bus_mux = 0; ale_a6 = 1'b0; addr_lo = 6'h2A; fsel = 2'd3;
      cs_n = 1'b0; ad_in = 8'hE1; wr_rw = 1'b0;
      @(negedge clk); wr_rw = 1'b1; rd_ds = 1'b0;
      @(posedge clk); #1;
      check("R7 read on commit edge", 32'(ad_out), 32'hE1);
      exp_mem[3][7'h2A] = 8'hE1;
      @(negedge clk); rd_ds = 1'b1; cs_n = 1'b1;

      // R10 interrupt combining
      @(negedge clk); bank_stat = 4'b0100; #0.5;
      check("R10 not yet asserted", 32'(irq_pull), 32'd0);
      @(posedge clk); #1;
      check("R10 asserted", 32'(irq_pull), 32'd1);
      @(negedge clk); bank_stat = 4'b1001;
      @(posedge clk); #1;
      check("R10 held", 32'(irq_pull), 32'd1);
      @(negedge clk); bank_stat = 4'b0000;
      @(posedge clk); #1;
      check("R10 released", 32'(irq_pull), 32'd0);

      // random mix over all conventions and addressing modes
      for (int n = 0; n < 400; n++) begin
         bit moto, mux, wr, cs_on;
         logic [1:0] bk;
         logic [6:0] ad;
         moto  = 1'($urandom);
         mux   = 1'($urandom);
         wr    = 1'($urandom);
         cs_on = ($urandom % 8) != 0;
         bk    = 2'($urandom);
         ad    = ($urandom % 4 == 0) ? 7'($urandom % 4) : 7'($urandom);
         access(moto, mux, cs_on, wr, bk, ad, 8'($urandom));
      end
      // final sweep of low addresses in every bank
      for (int b = 0; b < 4; b++)
         for (int a = 0; a < 4; a++) access(0, 0, 1, 0, 2'(b), 7'(a), 8'h00);

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule